// File: doc/BRIEF.md
# Clock Power Management Controller

This block sits beside a small 8-bit microcontroller core and decides how fast the core is clocked. Software writes one 8-bit control register to ask for stop mode, where the clock is halted, or for slow mode, where the clock runs at a reduced rate. Two registered indicator outputs carry that choice to external clock-gating and clock-divider circuits. Those circuits are not part of this block.

Two enable bits turn on a boost path. With the serial-port enable set, a busy UART pulls the core back to full speed. With the interrupt enable set, a pending or in-service interrupt does the same. Once the event is over, slow mode comes back without any software action, provided the slow request bit is still set. An interrupt request also wakes the core from stop mode, whatever the enable bits hold.

Top module: `clkpm_unit`

## Requirements
- R1: While reset (active-low) is asserted and right after it, the control register reads 0x00 and both stopInd and slowInd are 0, so the core runs at full speed.
- R2: A write (regWrEn high) loads regWrData[3:0] into the control register one cycle later. The bits are: bit 0 stop request, bit 1 slow request, bit 2 UART boost enable, bit 3 interrupt boost enable. Bits 7:4 always read back as 0 on regRdData.
- R3: stopInd equals the stop request bit and goes to 1 in the cycle after a write that sets bit 0.
- R4: slowInd is 1 in the cycle after the slow request bit is set, provided the stop bit is clear and no boost condition is active.
- R5: Stop has priority. If bits 0 and 1 are both set, stopInd is 1 and slowInd is 0.
- R6: An intReq pulse while stopped clears the stop bit, which reads back as 0, and drops stopInd in the next cycle. The boost enable bits have no effect on this wake.
- R7: When bit 2 is set, uartBusy forces slowInd to 0 in the next cycle. When bit 2 is clear, uartBusy is ignored.
- R8: When bit 3 is set, intReq or intInService forces slowInd to 0 in the next cycle. When bit 3 is clear, both are ignored for speed selection.
- R9: Once every active boost condition has ended, slowInd returns to 1 in the next cycle if the slow request bit is still set. The control register is not altered by a boost.
- R10: If a write that sets the stop bit lands in the same cycle as intReq, the wake wins. The stop bit stays 0 and stopInd stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Control register read-back |
| uartBusy | input | 1 | UART is sending or receiving |
| intReq | input | 1 | Enabled interrupt request pending |
| intInService | input | 1 | Interrupt handler is running |
| stopInd | output | 1 | Halt the core clock |
| slowInd | output | 1 | Run the core clock at reduced rate |

## Verification
A software write to the stop bit and a hardware wake by interrupt can fall in the same clock edge. Both try to change the same register bit. The bench drives regWrEn with bit 0 set while intReq is high in that one cycle. It then expects stopInd to stay 0 and the read-back stop bit to be clear in the following cycle. A boost that starts while a write changes the slow request bit is also driven in a single cycle. In that case the result must show the new register value together with the boost override.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;
  localparam int unsigned CTRL_BITS = 4;
  localparam int unsigned STOP_BIT  = 0;
  localparam int unsigned SLOW_BIT  = 1;
  localparam int unsigned UART_BIT  = 2;
  localparam int unsigned INT_BIT   = 3;

  typedef struct packed {
    logic loadCtrl;
    logic wakeStop;
    logic boost;
  } pmStrobe_t;
endpackage

// File: rtl/clkpm_control.sv
module clkpm_control
  import clkpm_pkg::*;
(
  input  logic      regWrEn,
  input  logic      uartBusy,
  input  logic      intReq,
  input  logic      intInService,
  input  logic      uartBoostEn,
  input  logic      intBoostEn,
  output pmStrobe_t strb
);
  logic uartBoost;
  logic intBoost;

  always_comb begin
    uartBoost     = uartBoostEn & uartBusy;
    intBoost      = intBoostEn & (intReq | intInService);
    strb.loadCtrl = regWrEn;
    // a pending interrupt always ends stop mode, regardless of enables
    strb.wakeStop = intReq;
    strb.boost    = uartBoost | intBoost;
  end
endmodule

// File: rtl/clkpm_datapath.sv
module clkpm_datapath
  import clkpm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pmStrobe_t            strb,
  input  logic [CTRL_BITS-1:0] wrBits,
  output logic [CTRL_BITS-1:0] ctrlBits,
  output logic                 stopInd,
  output logic                 slowInd
);
  logic [CTRL_BITS-1:0] ctrlNext;
  logic                 slowNext;

  always_comb begin
    ctrlNext = strb.loadCtrl ? wrBits : ctrlBits;
    // hardware wake overrides a software stop request in the same cycle
    if (strb.wakeStop) ctrlNext[STOP_BIT] = 1'b0;
    slowNext = ctrlNext[SLOW_BIT] & ~ctrlNext[STOP_BIT] & ~strb.boost;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlBits <= '0;
      slowInd  <= 1'b0;
    end else begin
      ctrlBits <= ctrlNext;
      slowInd  <= slowNext;
    end
  end

  assign stopInd = ctrlBits[STOP_BIT];
endmodule

// File: rtl/clkpm_unit.sv
module clkpm_unit
  import clkpm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              uartBusy,
  input  logic              intReq,
  input  logic              intInService,
  output logic              stopInd,
  output logic              slowInd
);
  localparam int unsigned PAD_W = DATA_W - CTRL_BITS;

  pmStrobe_t            strb;
  logic [CTRL_BITS-1:0] ctrlBits;
  logic                 unusedHiBits;

  assign unusedHiBits = ^regWrData[DATA_W-1:CTRL_BITS];

  clkpm_control u_control (
    .regWrEn      (regWrEn),
    .uartBusy     (uartBusy),
    .intReq       (intReq),
    .intInService (intInService),
    .uartBoostEn  (ctrlBits[UART_BIT]),
    .intBoostEn   (ctrlBits[INT_BIT]),
    .strb         (strb)
  );

  clkpm_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrBits   (regWrData[CTRL_BITS-1:0]),
    .ctrlBits (ctrlBits),
    .stopInd  (stopInd),
    .slowInd  (slowInd)
  );

  assign regRdData = {{PAD_W{1'b0}}, ctrlBits};
endmodule

// File: rtl/clkpm_unit_chk.sv
module clkpm_unit_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              uartBusy,
  input logic              intReq,
  input logic              intInService,
  input logic              stopInd,
  input logic              slowInd
);
  assert_hi_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:4] == '0);

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData[3:1] == $past(regWrData[3:1]));

  assert_stop_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[0] && !intReq) |=> stopInd);

  assert_slow_on_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && regRdData[1] && !regRdData[0] && !uartBusy && !intReq
     && !intInService) |=> slowInd);

  assert_stop_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopInd |-> !slowInd);

  assert_wake_R6: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && stopInd) |=> !stopInd);

  assert_uart_boost_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[2] && uartBusy) |=> !slowInd);

  assert_int_boost_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[3] && (intReq || intInService)) |=> !slowInd);

  assert_wake_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[0] && intReq) |=> !stopInd);
endmodule

bind clkpm_unit clkpm_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regWrEn      (regWrEn),
  .regWrData    (regWrData),
  .regRdData    (regRdData),
  .uartBusy     (uartBusy),
  .intReq       (intReq),
  .intInService (intInService),
  .stopInd      (stopInd),
  .slowInd      (slowInd)
);

// File: tb/clkpm_unit_bench.sv
`timescale 1ns/1ps
module clkpm_unit_bench;
  typedef struct {
    logic       stop;
    logic       slow;
    logic [7:0] rd;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       uartBusy = 1'b0;
  logic       intReq = 1'b0;
  logic       intInService = 1'b0;
  logic       stopInd;
  logic       slowInd;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];
  logic [3:0] mReg = 4'h0;
  logic       mSlow = 1'b0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  clkpm_unit u_clkpm_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .uartBusy(uartBusy), .intReq(intReq),
    .intInService(intInService), .stopInd(stopInd), .slowInd(slowInd)
  );

  task automatic compare(input expItem_t e);
    checks++;
    if (stopInd !== e.stop || slowInd !== e.slow || regRdData !== e.rd) begin
      errors++;
      $display("FAIL %s: got stop=%b slow=%b rd=%h, expected stop=%b slow=%b rd=%h",
               e.tag, stopInd, slowInd, regRdData, e.stop, e.slow, e.rd);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] data, input logic uart,
                      input logic intr, input logic insvc, input string tag);
    expItem_t e;
    logic [3:0] nReg;
    logic boost;
    @(negedge clk);
    regWrEn = we; regWrData = data; uartBusy = uart;
    intReq = intr; intInService = insvc;
    boost = (mReg[2] & uart) | (mReg[3] & (intr | insvc));
    nReg = we ? data[3:0] : mReg;
    if (intr) nReg[0] = 1'b0;
    mSlow = nReg[1] & ~nReg[0] & ~boost;
    mReg = nReg;
    e.stop = mReg[0]; e.slow = mSlow; e.rd = {4'h0, mReg}; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    expItem_t e0;
    #12;
    e0.stop = 0; e0.slow = 0; e0.rd = 8'h00; e0.tag = "R1 in reset";
    compare(e0);
    @(negedge clk); rstN = 1'b1;
    step(0, 8'h00, 0, 0, 0, "R1 after reset");
    step(1, 8'hF2, 0, 0, 0, "R2 load with high bits R4");
    step(0, 8'h00, 0, 0, 0, "R4 slow held");
    step(1, 8'h01, 0, 0, 0, "R3 stop set");
    step(1, 8'h03, 0, 0, 0, "R5 stop over slow");
    step(0, 8'h00, 0, 1, 0, "R6 wake no enables");
    step(0, 8'h00, 0, 0, 0, "R6 awake slow back");
    step(0, 8'h00, 1, 0, 0, "R7 uart ignored when disabled");
    step(0, 8'h00, 0, 1, 1, "R8 int ignored when disabled");
    step(1, 8'h06, 0, 0, 0, "R2 uart enable");
    step(0, 8'h00, 1, 0, 0, "R7 uart boost");
    step(0, 8'h00, 1, 0, 0, "R7 uart boost held");
    step(0, 8'h00, 0, 0, 0, "R9 restore after uart");
    step(1, 8'h0A, 0, 0, 0, "R2 int enable");
    step(0, 8'h00, 0, 1, 0, "R8 int request boost");
    step(0, 8'h00, 0, 0, 1, "R8 in service boost");
    step(0, 8'h00, 1, 0, 0, "R8 uart now ignored");
    step(0, 8'h00, 0, 0, 0, "R9 restore after int");
    step(1, 8'h0B, 0, 1, 0, "R10 wake wins over stop write");
    step(1, 8'h0F, 0, 0, 0, "R5 stop with enables");
    step(0, 8'h00, 1, 0, 0, "R7 uart while stopped");
    step(0, 8'h00, 0, 1, 0, "R6 wake with int boost");
    step(0, 8'h00, 0, 0, 0, "R9 slow after wake");
    step(1, 8'h06, 1, 0, 0, "R7 write same cycle as uart");
    step(1, 8'h00, 0, 0, 0, "R2 clear all");
    step(0, 8'h00, 0, 0, 0, "R2 idle");
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule